// File: doc/BRIEF.md
# Software Acknowledge Resource Tracker

This block sits at a destination node and owns a small pool of acknowledge resources. The local message receiver asks for a resource for each incoming broadcast message. The tracker grants the lowest free index, or refuses with a busy response when the pool is full, and records which sender the message came from. The resource then stays held until local software acknowledges it. Every held message produces exactly one reply to its sender. A software acknowledge produces a normal reply. An expired timeout produces an error reply.

Software drives the block through a single register write port with two targets. The acknowledge target is write-one-to-clear on a status word. That word carries one pending bit per resource in its low bits and one timeout bit per resource starting at bit 8. The control target holds a forced-timeout selector, a timebase toggle bit, a 4-bit timeout period and a soft-acknowledge mode enable.

A timed-out resource has already sent its error reply, but it stays held until software clears its timeout bit. Clearing that bit sends nothing more. Replies leave one per cycle through a registered output, lowest resource index first.

Top module: `sack_tracker`

## Requirements
- R1: After reset the status word is all zero, no reply is valid, mode is off and the period is 0. Status bits 6:0 are the pending bits, bits 14:8 are the timeout bits, and bit 7 always reads 0.
- R2: When `alloc_req` is high and a resource is free, `alloc_grant` is high in the same cycle and `alloc_idx` is the lowest free index. The pending bit of that index is set after the clock edge, and the requesting source is stored with the resource.
- R3: A resource counts as held while its pending bit, its timeout bit or its outstanding reply is set. When all resources are held, `alloc_req` gives `alloc_busy` high and `alloc_grant` low. Grant and busy are never high together.
- R4: An acknowledge write (`wr_sel`=0) with a one in bit i clears the pending bit of resource i when it is pending. That resource then sends one reply with `rsp_err`=0 and `rsp_dst` equal to its stored source.
- R5: Timeouts only run while mode is on. Each resource loads its counter with the period when it is granted. The counter counts down on every tick of a timebase that fires once every PRESC cycles. On the tick that finds the counter at 0, the pending bit moves to the timeout bit and an error reply (`rsp_err`=1) is sent. This happens between period*PRESC+1 and (period+1)*PRESC cycles after the grant.
- R6: A timed-out resource stays held. Clearing its pending bit has no effect and sends no reply. Clearing its timeout bit frees it and sends no reply.
- R7: Each granted message gets exactly one reply. Replies are registered, one per cycle, lowest index first. A reply appears at the earliest one cycle after the event that caused it.
- R8: In a control write (`wr_sel`=1), bits 2:0 are the selector, bit 3 is the timebase toggle, bits 7:4 are the period and bit 8 is the mode. The period is taken only if mode was off before that write.
- R9: When mode is on, a control write whose bit 3 differs from the stored toggle forces an immediate timeout of the selected pending resource. A selector of 7 forces all pending resources. A write that keeps bit 3 unchanged forces nothing.
- R10: While mode is off, neither the counters nor a toggle of bit 3 time out any resource.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Receiver asks for a resource for a new message |
| alloc_src | input | SRCW | Sender identity of the new message |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_busy | output | 1 | Request refused, pool full |
| alloc_idx | output | IW | Index granted (lowest free) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = acknowledge (W1C), 1 = control |
| wr_data | input | DW | Write data |
| stat_o | output | DW | Status word: pending bits and timeout bits |
| rsp_valid | output | 1 | A reply leaves this cycle |
| rsp_err | output | 1 | Reply is an error (timeout) reply |
| rsp_idx | output | IW | Resource the reply belongs to |
| rsp_dst | output | SRCW | Sender the reply goes to |

## Verification
Some properties are checked on every cycle. Grant and busy are never high together. A grant always leaves its pending bit set. Bit 7 of the status word always reads 0. Every reply comes from an outstanding reply entry. New timeout bits appear only while mode is on. The period never changes while mode is on. The bench scenarios cover the rest, against a cycle model built from the requirements: timing of natural timeouts, the locked period, forced timeouts with single and all-resource selectors, held timed-out resources that free silently, and the one-reply-per-message balance after random traffic is drained.

// File: rtl/sack_pkg.sv
`timescale 1ns/1ps
package sack_pkg;
    // width of the timeout period field
    localparam int PERW        = 4;
    // bit offset of the timeout group in the status word
    localparam int TO_OFS      = 8;
    // control write field positions
    localparam int CTL_SEL_LSB = 0;
    localparam int CTL_TB_BIT  = 3;
    localparam int CTL_PER_LSB = 4;
    localparam int CTL_MODE    = 8;
endpackage

// File: rtl/sack_prio.sv
`timescale 1ns/1ps
// lowest-index-first priority encoder
module sack_prio #(
    parameter int N  = 7,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/sack_tick.sv
`timescale 1ns/1ps
// prescaled timebase: one tick every PRESC cycles
module sack_tick #(
    parameter int PRESC = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (PRESC <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(PRESC);
            logic [CW-1:0] cnt_d, cnt_q;
            always_comb begin
                tick  = (cnt_q == CW'(PRESC - 1));
                cnt_d = tick ? '0 : cnt_q + 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end
    endgenerate
endmodule

// File: rtl/sack_timer.sv
`timescale 1ns/1ps
// per-resource timeout down-counter
module sack_timer #(
    parameter int PERW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PERW-1:0] load_val,
    input  logic            tick,
    input  logic            run,
    output logic            expire
);
    logic [PERW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = tick && run && (cnt_q == '0) && !load;
        cnt_d  = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (tick && run && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sack_tracker.sv
`timescale 1ns/1ps
module sack_tracker
    import sack_pkg::*;
#(
    parameter  int NRES  = 7,
    parameter  int SRCW  = 6,
    parameter  int PRESC = 4,
    localparam int IW    = $clog2(NRES + 1),
    localparam int DW    = TO_OFS + NRES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_req,
    input  logic [SRCW-1:0] alloc_src,
    output logic            alloc_grant,
    output logic            alloc_busy,
    output logic [IW-1:0]   alloc_idx,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   stat_o,
    output logic            rsp_valid,
    output logic            rsp_err,
    output logic [IW-1:0]   rsp_idx,
    output logic [SRCW-1:0] rsp_dst
);
    typedef struct packed {
        logic [NRES-1:0]            pend;
        logic [NRES-1:0]            tout;
        logic [NRES-1:0]            due;   // reply owed
        logic [NRES-1:0]            err;   // owed reply is an error reply
        logic [NRES-1:0][SRCW-1:0]  dst;
        logic                       mode;
        logic                       tb;
        logic [PERW-1:0]            period;
        logic                       rv;
        logic                       re;
        logic [IW-1:0]              ri;
        logic [SRCW-1:0]            rd;
    } st_t;

    st_t q, d;

    logic [NRES-1:0] free_v, grant_oh, expire;
    logic            any_free, any_due, tick;
    logic [IW-1:0]   free_idx, due_idx;

    assign free_v = ~(q.pend | q.tout | q.due);

    sack_prio #(.N(NRES), .IW(IW)) u_alloc_pick (
        .req(free_v), .any(any_free), .idx(free_idx)
    );
    sack_prio #(.N(NRES), .IW(IW)) u_reply_pick (
        .req(q.due), .any(any_due), .idx(due_idx)
    );
    sack_tick #(.PRESC(PRESC)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    assign alloc_grant = alloc_req && any_free;
    assign alloc_busy  = alloc_req && !any_free;
    assign alloc_idx   = free_idx;
    assign grant_oh    = alloc_grant ? (NRES'(1) << free_idx) : '0;

    generate
        for (genvar g = 0; g < NRES; g++) begin : g_tmr
            sack_timer #(.PERW(PERW)) u_tmr (
                .clk(clk), .rst_n(rst_n),
                .load(grant_oh[g]), .load_val(q.period),
                .tick(tick), .run(q.mode && q.pend[g]),
                .expire(expire[g])
            );
        end
    endgenerate

    always_comb begin
        logic            ack_wr, ctl_wr;
        logic [NRES-1:0] clr_p, clr_t, force_v, to_ev, ack_ev, pick_oh;
        logic [IW-1:0]   fsel;

        d      = q;
        ack_wr = wr_en && !wr_sel;
        ctl_wr = wr_en && wr_sel;
        clr_p  = ack_wr ? wr_data[NRES-1:0]     : '0;
        clr_t  = ack_wr ? wr_data[TO_OFS +: NRES] : '0;

        // forced timeout on a reversal of the toggle bit while mode is on
        fsel    = wr_data[CTL_SEL_LSB +: IW];
        force_v = '0;
        if (ctl_wr && q.mode && (wr_data[CTL_TB_BIT] != q.tb))
            force_v = (fsel == {IW{1'b1}}) ? '1 : (NRES'(1) << fsel);

        // software clear wins over a timeout in the same cycle
        to_ev  = (expire | force_v) & q.pend & ~clr_p;
        ack_ev = clr_p & q.pend;

        d.pend = (q.pend & ~clr_p & ~to_ev) | grant_oh;
        d.tout = (q.tout & ~clr_t) | to_ev;

        pick_oh = any_due ? (NRES'(1) << due_idx) : '0;
        d.due   = (q.due & ~pick_oh) | ack_ev | to_ev;

        for (int i = 0; i < NRES; i++) begin
            if (ack_ev[i] || to_ev[i]) d.err[i] = to_ev[i];
            if (grant_oh[i])           d.dst[i] = alloc_src;
        end

        d.rv = any_due;
        d.re = any_due ? q.err[due_idx] : 1'b0;
        d.ri = any_due ? due_idx        : '0;
        d.rd = any_due ? q.dst[due_idx] : '0;

        if (ctl_wr) begin
            d.tb = wr_data[CTL_TB_BIT];
            if (!q.mode) d.period = wr_data[CTL_PER_LSB +: PERW];
            d.mode = wr_data[CTL_MODE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        stat_o                 = '0;
        stat_o[NRES-1:0]       = q.pend;
        stat_o[TO_OFS +: NRES] = q.tout;
    end

    assign rsp_valid = q.rv;
    assign rsp_err   = q.re;
    assign rsp_idx   = q.ri;
    assign rsp_dst   = q.rd;
endmodule

// File: rtl/sack_tracker_chk.sv
`timescale 1ns/1ps
module sack_tracker_chk
    import sack_pkg::*;
#(
    parameter int NRES = 7,
    parameter int IW   = 3,
    parameter int DW   = 15
) (
    input logic            clk,
    input logic            rst_n,
    input logic            alloc_grant,
    input logic            alloc_busy,
    input logic [IW-1:0]   alloc_idx,
    input logic [DW-1:0]   stat,
    input logic            rsp_valid,
    input logic [IW-1:0]   rsp_idx,
    input logic [NRES-1:0] due,
    input logic            mode,
    input logic [PERW-1:0] period
);
    logic [NRES-1:0] due_prev, tout_prev;
    logic            mode_prev;
    logic [PERW-1:0] per_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            due_prev  <= '0;
            tout_prev <= '0;
            mode_prev <= 1'b0;
            per_prev  <= '0;
        end else begin
            due_prev  <= due;
            tout_prev <= stat[TO_OFS +: NRES];
            mode_prev <= mode;
            per_prev  <= period;
        end
    end

    p_grant_busy_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_grant && alloc_busy));

    p_grant_sets_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |=> stat[$past(alloc_idx)]);

    p_gap_bit_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stat[TO_OFS-1:NRES] == '0);

    p_reply_from_due_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> due_prev[rsp_idx]);

    p_timeout_needs_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat[TO_OFS +: NRES] & ~tout_prev)) |-> mode_prev);

    p_period_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (period != per_prev) |-> !mode_prev);
endmodule

bind sack_tracker sack_tracker_chk #(.NRES(NRES), .IW(IW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .alloc_grant(alloc_grant), .alloc_busy(alloc_busy), .alloc_idx(alloc_idx),
    .stat(stat_o), .rsp_valid(rsp_valid), .rsp_idx(rsp_idx),
    .due(q.due), .mode(q.mode), .period(q.period)
);

// File: tb/sack_tracker_tb.sv
`timescale 1ns/1ps
module sack_tracker_tb_top;
    localparam int PRESC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_req = 1'b0;
    logic [5:0]  a_src = '0;
    logic        w_en = 1'b0;
    logic        w_sel = 1'b0;
    logic [14:0] w_dat = '0;
    logic        alloc_grant, alloc_busy, rsp_valid, rsp_err;
    logic [2:0]  alloc_idx, rsp_idx;
    logic [14:0] stat_o;
    logic [5:0]  rsp_dst;

    int tests = 0, fails = 0, grants = 0, replies = 0;
    logic btb = 1'b0;

    always #2.5 clk = ~clk;

    sack_tracker #(.NRES(7), .SRCW(6), .PRESC(PRESC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(a_req), .alloc_src(a_src),
        .alloc_grant(alloc_grant), .alloc_busy(alloc_busy), .alloc_idx(alloc_idx),
        .wr_en(w_en), .wr_sel(w_sel), .wr_data(w_dat),
        .stat_o(stat_o),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_idx(rsp_idx), .rsp_dst(rsp_dst)
    );

    // ---------------- reference model from the requirements ----------------
    logic [6:0] m_pend, m_tout, m_due, m_err;
    logic [5:0] m_dst [7];
    logic [3:0] m_cnt [7];
    int         m_presc;
    logic       m_mode, m_tb, m_rv, m_re;
    logic [3:0] m_per;
    logic [2:0] m_ri;
    logic [5:0] m_rd;

    always @(posedge clk) begin : model
        logic [6:0] held, gnt, clrp, clrt, frc, expv, toe, acke, pk;
        logic tick;
        if (!rst_n) begin
            m_pend = '0; m_tout = '0; m_due = '0; m_err = '0;
            for (int i = 0; i < 7; i++) begin m_dst[i] = '0; m_cnt[i] = '0; end
            m_presc = 0; m_mode = 0; m_tb = 0; m_per = '0;
            m_rv = 0; m_re = 0; m_ri = '0; m_rd = '0;
        end else begin
            held = m_pend | m_tout | m_due;
            gnt  = '0;
            if (a_req)
                for (int i = 0; i < 7; i++) if (!held[i] && gnt == '0) gnt[i] = 1'b1;
            tick = (m_presc == PRESC - 1);
            clrp = (w_en && !w_sel) ? w_dat[6:0]  : 7'h0;
            clrt = (w_en && !w_sel) ? w_dat[14:8] : 7'h0;
            frc  = '0;
            if (w_en && w_sel && m_mode && (w_dat[3] != m_tb))
                frc = (w_dat[2:0] == 3'd7) ? 7'h7f : (7'd1 << w_dat[2:0]);
            for (int i = 0; i < 7; i++)
                expv[i] = tick && m_mode && m_pend[i] && (m_cnt[i] == 4'd0);
            toe  = (expv | frc) & m_pend & ~clrp;
            acke = clrp & m_pend;
            pk   = '0;
            for (int i = 0; i < 7; i++) if (m_due[i] && pk == '0) pk[i] = 1'b1;
            m_rv = |m_due; m_re = 0; m_ri = '0; m_rd = '0;
            for (int i = 0; i < 7; i++)
                if (pk[i]) begin m_re = m_err[i]; m_ri = 3'(i); m_rd = m_dst[i]; end
            for (int i = 0; i < 7; i++) begin
                if (gnt[i]) m_cnt[i] = m_per;
                else if (tick && m_mode && m_pend[i] && m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
                if (acke[i] || toe[i]) m_err[i] = toe[i];
                if (gnt[i]) m_dst[i] = a_src;
            end
            m_due  = (m_due & ~pk) | acke | toe;
            m_pend = (m_pend & ~clrp & ~toe) | gnt;
            m_tout = (m_tout & ~clrt) | toe;
            if (w_en && w_sel) begin
                m_tb = w_dat[3];
                if (!m_mode) m_per = w_dat[7:4];
                m_mode = w_dat[8];
            end
            m_presc = tick ? 0 : m_presc + 1;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
        end
    endtask

    // one cycle: inputs already set at the current negedge
    task automatic step();
        logic [6:0] held;
        int         eidx;
        #1;
        held = m_pend | m_tout | m_due;
        eidx = -1;
        for (int i = 6; i >= 0; i--) if (!held[i]) eidx = i;
        chk(alloc_busy == (a_req && eidx < 0), "R3", "alloc_busy", alloc_busy, a_req && eidx < 0);
        chk(alloc_grant == (a_req && eidx >= 0), "R2", "alloc_grant", alloc_grant, a_req && eidx >= 0);
        if (a_req && eidx >= 0) begin
            chk(int'(alloc_idx) == eidx, "R2", "alloc_idx", alloc_idx, eidx);
            grants++;
        end
        @(negedge clk);
        a_req = 0; w_en = 0;
        chk(stat_o[6:0] == m_pend, "R2", "pending bits", stat_o[6:0], m_pend);
        chk(stat_o[14:8] == m_tout, "R5", "timeout bits", stat_o[14:8], m_tout);
        chk(stat_o[7] == 1'b0, "R1", "gap bit", stat_o[7], 0);
        chk(rsp_valid == m_rv, "R7", "rsp_valid", rsp_valid, m_rv);
        if (rsp_valid) begin
            replies++;
            chk(rsp_err == m_re, "R4", "rsp_err", rsp_err, m_re);
            chk(rsp_idx == m_ri, "R7", "rsp_idx", rsp_idx, m_ri);
            chk(rsp_dst == m_rd, "R4", "rsp_dst", rsp_dst, m_rd);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic alloc(input logic [5:0] src);
        a_req = 1; a_src = src; step();
    endtask

    task automatic ack(input logic [14:0] v);
        w_en = 1; w_sel = 0; w_dat = v; step();
    endtask

    task automatic ctl(input bit mode, input logic [3:0] per, input bit tb, input logic [2:0] sel);
        w_en = 1; w_sel = 1; w_dat = {6'd0, mode, per, tb, sel}; btb = tb; step();
    endtask

    task automatic expect_stat(input logic [14:0] exp, input string req, input string what);
        chk(stat_o == exp, req, what, stat_o, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 5);
        tests++; fails++;
        $display("FAIL watchdog expired act=hang exp=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int n;
        bit seen;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        expect_stat(15'h0, "R1", "status after reset");
        chk(rsp_valid == 0, "R1", "reply after reset", rsp_valid, 0);

        // R2: fill pool in index order, R3: busy when full
        for (int i = 0; i < 7; i++) alloc(6'(10 + i));
        expect_stat(15'h007f, "R2", "pool full");
        a_req = 1; #1;
        chk(alloc_busy && !alloc_grant, "R3", "busy when full", {alloc_busy, alloc_grant}, 2'b10);
        step();

        // R4: acknowledge resource 2, normal reply to its source
        ack(15'h0004);
        expect_stat(15'h007b, "R4", "pending 2 cleared");
        a_req = 1; #1;
        chk(alloc_busy == 1, "R3", "held while reply owed", alloc_busy, 1);
        step();
        chk(rsp_valid && !rsp_err && rsp_idx == 2 && rsp_dst == 12, "R4", "normal reply",
            {rsp_valid, rsp_err, rsp_idx, rsp_dst}, {1'b1, 1'b0, 3'd2, 6'd12});
        alloc(6'd33);

        // R5: mode on, all pending resources time out with error replies
        ctl(1, 4'd1, 0, 3'd0);
        idle(30);
        expect_stat(15'h7f00, "R5", "all timed out");

        // R6: timed-out resources stay held; pending clears do nothing
        a_req = 1; #1;
        chk(alloc_busy == 1, "R6", "timed-out still held", alloc_busy, 1);
        step();
        n = replies;
        ack(15'h007f);
        idle(3);
        chk(replies == n, "R6", "no reply on pending clear", replies, n);
        expect_stat(15'h7f00, "R6", "unchanged after pending clear");
        ack(15'h1000);
        idle(3);
        chk(replies == n, "R6", "no reply on timeout clear", replies, n);
        expect_stat(15'h6f00, "R6", "timeout 4 cleared");
        a_req = 1; a_src = 6'd5; #1;
        chk(alloc_grant && alloc_idx == 4, "R6", "freed index reused", alloc_idx, 4);
        step();
        ack(15'h7f7f);
        idle(4);
        expect_stat(15'h0, "R6", "all freed");

        // R8: period locked while mode on
        ctl(0, 4'd0, 0, 3'd0);
        ctl(1, 4'd1, 0, 3'd0);
        ctl(1, 4'd9, 0, 3'd0);
        alloc(6'd7);
        n = 0; seen = 0;
        for (int i = 0; i < 60 && !seen; i++) begin step(); n++; seen = stat_o[8]; end
        chk(seen && n >= 5 && n <= 8, "R8", "locked period 1 delay", n, 5);
        ack(15'h7f7f); idle(3);
        ctl(0, 4'd0, 0, 3'd0);
        ctl(1, 4'd9, 0, 3'd0);
        alloc(6'd8);
        n = 0; seen = 0;
        for (int i = 0; i < 80 && !seen; i++) begin step(); n++; seen = stat_o[8]; end
        chk(seen && n >= 37 && n <= 40, "R5", "period 9 delay", n, 37);
        ack(15'h7f7f); idle(3);

        // R9: forced timeouts
        ctl(0, 4'd0, 0, 3'd0);
        ctl(1, 4'd15, 0, 3'd0);
        alloc(6'd1); alloc(6'd2); alloc(6'd3);
        ctl(1, 4'd0, 1, 3'd1);
        expect_stat(15'h0205, "R9", "force single");
        ctl(1, 4'd0, 1, 3'd0);
        expect_stat(15'h0205, "R9", "no reversal no force");
        ctl(1, 4'd0, 0, 3'd7);
        expect_stat(15'h0700, "R9", "force all");
        idle(4);
        ack(15'h7f7f); idle(3);

        // R10: mode off, nothing times out
        ctl(0, 4'd0, btb, 3'd0);
        alloc(6'd9);
        idle(80);
        expect_stat(15'h0001, "R10", "no natural timeout");
        ctl(0, 4'd0, ~btb, 3'd7);
        expect_stat(15'h0001, "R10", "no forced timeout");
        ack(15'h7f7f); idle(3);

        // random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            a_req = ($urandom % 3) == 0;
            a_src = 6'($urandom);
            if (($urandom % 4) == 0) begin
                w_en  = 1;
                w_sel = ($urandom % 4) == 0;
                w_dat = 15'($urandom);
            end
            step();
        end

        // drain: R7 one reply per granted message
        ctl(0, 4'd0, 0, 3'd0);
        for (int i = 0; i < 3; i++) ack(15'h7f7f);
        idle(12);
        expect_stat(15'h0, "R7", "drained");
        chk(grants == replies, "R7", "one reply per message", replies, grants);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule